// File: doc/BRIEF.md
# Read-capture delay tap calibrator

This block finds a working read-capture delay for a two-lane memory interface. After a start pulse it steps a delay setting through every value from zero to the top of the range. At each value it loads the setting into both lane delay outputs and then launches a memory self-test. It holds that launch request until the self-test reports that it has finished, and then judges the result by its compare count.

While it sweeps, the block keeps track of the lowest and the highest setting that passed. When the sweep ends, it writes the midpoint of that span into both lanes. If no setting passed, it puts back the setting that was supplied when calibration started. A one-cycle completion pulse follows, and the number of passing settings stays visible until the next run.

A self-test that never answers cannot stall the sweep. A cycle limit on each wait marks that setting as failed and moves on.

Top module: `tap_sweep_cal`

## Requirements
- R1: After a synchronous active-low reset, `cal_done` and `bist_go` are 0, both lane outputs are 0 and `pass_count` is 0.
- R2: A sweep launches exactly one self-test per setting, in ascending order 0, 1, …, 63. At every rising edge of `bist_go`, both lane outputs carry that same setting.
- R3: `bist_go` stays high until `bist_status[0]` (finished flag) is seen high, and it drops on the following clock edge.
- R4: A setting passes only when the compare count in `bist_status[8:1]` equals exactly 8. Any other count, such as 7, 9 or 0, is a fail.
- R5: If any setting passed, both lanes end at (lowest passing + highest passing) / 2, using integer division and reduced modulo 64. Failing settings between the two do not move the result.
- R6: If no setting passed, both lanes end at the value `init_tap` had in the cycle when `cal_start` was taken.
- R7: When `cal_done` is high, `pass_count` equals the number of passing settings in the sweep, from 0 to 64.
- R8: `cal_done` is high for exactly one cycle, after the final lane value has been written. The lanes already hold that value in the cycle in which `cal_done` is high.
- R9: If the finished flag does not arrive within TIMEOUT cycles (200 by default) of launch, `bist_go` drops and that setting counts as a fail.
- R10: A `cal_start` pulse that arrives during a sweep is ignored. The sweep continues unchanged and produces a single `cal_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Starts a sweep when idle |
| init_tap | input | 6 | Setting restored when nothing passes |
| bist_status | input | 9 | Bit 0 finished flag, bits [8:1] compare count |
| bist_go | output | 1 | Self-test launch request, held until finished |
| lane0_tap | output | 6 | Delay setting for lane 0 |
| lane1_tap | output | 6 | Delay setting for lane 1 |
| cal_done | output | 1 | One-cycle completion pulse |
| pass_count | output | 7 | Number of passing settings in the last sweep |

## Verification
The hardest cases to reach from the ports are those where the result depends on more than a clean contiguous window. These are a self-test that never answers on some settings, passing settings that are not contiguous, and counts that are off by one from the expected value. A behavioural responder in the bench answers each launch using a per-setting table of pass, fail value and hang, with random latency. Directed tables cover an empty window, a window of one setting at either end, and two isolated passes far apart. Seeded random tables cover mixed windows.

// File: rtl/tapcal_pkg.sv
// Package: shared types for the delay tap sweep calibrator.
// Assumes: none; holds only state encodings and the result record.
package tapcal_pkg;

    // Sweep sequencer states.
    typedef enum logic [2:0] {
        SW_IDLE,
        SW_APPLY,
        SW_WAIT,
        SW_FINAL,
        SW_DONE
    } sweep_state_t;

    // Self-test handshake states.
    typedef enum logic {
        HS_IDLE,
        HS_BUSY
    } hs_state_t;

    // Outcome of one self-test, valid for a single cycle.
    typedef struct packed {
        logic valid;
        logic pass;
        logic timed_out;
    } test_result_t;

endpackage

// File: rtl/bist_handshake.sv
// Module: bist_handshake
// Launches one self-test when launch pulses and holds go until the finished
// flag (status bit 0) is seen. It then grades the count in status[CNT_W:1]
// against EXPECT_CNT and reports a one-cycle result.
// Assumes: launch comes only while idle. The finished flag falls after go
// falls, before the next launch. TIMEOUT bounds the wait.
module bist_handshake
    import tapcal_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int EXPECT_CNT = 8,
    parameter int TIMEOUT    = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [CNT_W:0]   status_i,
    output logic             go_o,
    output test_result_t     res_o
);

    localparam int TMR_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] EXP_L   = CNT_W'(EXPECT_CNT);
    localparam logic [TMR_W-1:0] TMR_END = TMR_W'(TIMEOUT - 1);

    hs_state_t          state;
    logic [TMR_W-1:0]   timer;
    logic               fin_seen;
    logic [CNT_W-1:0]   cnt_seen;

    assign fin_seen = status_i[0];
    assign cnt_seen = status_i[CNT_W:1];

    // Launch, wait for finished or timeout, then grade the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HS_IDLE;
            go_o  <= 1'b0;
            timer <= '0;
            res_o <= '0;
        end else begin
            res_o <= '0;
            case (state)
                HS_IDLE: begin
                    if (launch) begin
                        go_o  <= 1'b1;
                        timer <= '0;
                        state <= HS_BUSY;
                    end
                end
                HS_BUSY: begin
                    if (fin_seen) begin
                        go_o            <= 1'b0;
                        res_o.valid     <= 1'b1;
                        res_o.pass      <= (cnt_seen == EXP_L);
                        state           <= HS_IDLE;
                    end else if (timer == TMR_END) begin
                        go_o            <= 1'b0;
                        res_o.valid     <= 1'b1;
                        res_o.timed_out <= 1'b1;
                        state           <= HS_IDLE;
                    end else begin
                        timer <= timer + TMR_W'(1);
                    end
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    // R3: go drops the cycle after the finished flag is seen.
    assert_go_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && fin_seen) |=> !go_o);

    // R3: go is held while waiting and the limit has not been reached.
    assert_go_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && !fin_seen && timer < TMR_END) |=> go_o);

    // R9: a timed-out test is never graded as a pass.
    assert_timeout_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_o.timed_out |-> (res_o.valid && !res_o.pass));

    // R4: a pass result only follows a seen finished flag with count equal.
    assert_pass_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_o.pass) |-> ($past(cnt_seen) == EXP_L && $past(fin_seen)));

endmodule

// File: rtl/tap_window_track.sv
// Module: tap_window_track
// Records the lowest and highest passing setting of a sweep and counts
// the passes. It gives the midpoint of the span, reduced modulo the range.
// Assumes: updates come in ascending setting order; clear precedes a sweep.
module tap_window_track #(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             upd,
    input  logic             pass,
    input  logic [TAP_W-1:0] tap,
    output logic             any_pass_o,
    output logic [TAP_W-1:0] centre_o,
    output logic [TAP_W:0]   pass_cnt_o
);

    localparam int TAPS = 1 << TAP_W;

    logic             seen;
    logic [TAP_W-1:0] low_q;
    logic [TAP_W-1:0] high_q;
    logic [TAP_W:0]   span_sum;
    logic [TAP_W:0]   span_half;

    // Track the first and last pass; the seen flag marks "none yet".
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            seen       <= 1'b0;
            low_q      <= '0;
            high_q     <= '0;
            pass_cnt_o <= '0;
        end else if (upd && pass) begin
            if (!seen) begin
                low_q <= tap;
                seen  <= 1'b1;
            end
            high_q     <= tap;
            pass_cnt_o <= pass_cnt_o + (TAP_W+1)'(1);
        end
    end

    // Midpoint of the span with integer division, wrapped into the range.
    always_comb begin
        span_sum  = {1'b0, low_q} + {1'b0, high_q};
        span_half = span_sum >> 1;
        centre_o  = span_half[TAP_W-1:0];
    end

    assign any_pass_o = seen;

    // R5: with ascending updates the low end never exceeds the high end.
    assert_span_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (low_q <= high_q));

    // R5: the first pass fixes the low end at that setting.
    assert_first_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && upd && pass && !seen) |=> (seen && low_q == $past(tap)));

    // R7: the pass count never exceeds the number of settings.
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pass_cnt_o <= (TAP_W+1)'(TAPS));

endmodule

// File: rtl/tap_sweep_cal.sv
// Module: tap_sweep_cal (top)
// Sweeps the delay setting from 0 to the top of the range. It runs one
// self-test per setting through bist_handshake and feeds the results to
// tap_window_track. It then writes the midpoint, or the saved initial
// setting if nothing passed, into every lane and pulses cal_done.
// Assumes: cal_start is only taken when idle; both lanes share one value.
module tap_sweep_cal
    import tapcal_pkg::*;
#(
    parameter int TAP_W      = 6,
    parameter int CNT_W      = 8,
    parameter int EXPECT_CNT = 8,
    parameter int TIMEOUT    = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_start,
    input  logic [TAP_W-1:0] init_tap,
    input  logic [CNT_W:0]   bist_status,
    output logic             bist_go,
    output logic [TAP_W-1:0] lane0_tap,
    output logic [TAP_W-1:0] lane1_tap,
    output logic             cal_done,
    output logic [TAP_W:0]   pass_count
);

    localparam int NUM_LANES = 2;
    localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'((1 << TAP_W) - 1);

    sweep_state_t     state;
    logic [TAP_W-1:0] tap_idx;
    logic [TAP_W-1:0] saved_tap;
    logic             launch;
    test_result_t     res;
    logic             trk_clear;
    logic             trk_upd;
    logic             any_pass;
    logic [TAP_W-1:0] centre;
    logic             lane_ld;
    logic [TAP_W-1:0] lane_nxt;
    logic [TAP_W-1:0] lane_q [NUM_LANES];

    assign launch    = (state == SW_APPLY);
    assign trk_clear = (state == SW_IDLE) && cal_start;
    assign trk_upd   = (state == SW_WAIT) && res.valid;
    assign cal_done  = (state == SW_DONE);

    // Sweep sequencer: start, apply, wait per setting, finalise, signal done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SW_IDLE;
            tap_idx   <= '0;
            saved_tap <= '0;
        end else begin
            case (state)
                SW_IDLE: begin
                    if (cal_start) begin
                        saved_tap <= init_tap;
                        tap_idx   <= '0;
                        state     <= SW_APPLY;
                    end
                end
                SW_APPLY: state <= SW_WAIT;
                SW_WAIT: begin
                    if (res.valid) begin
                        if (tap_idx == TAP_LAST) begin
                            state <= SW_FINAL;
                        end else begin
                            tap_idx <= tap_idx + TAP_W'(1);
                            state   <= SW_APPLY;
                        end
                    end
                end
                SW_FINAL: state <= SW_DONE;
                SW_DONE:  state <= SW_IDLE;
                default:  state <= SW_IDLE;
            endcase
        end
    end

    // Choose when and what to load into the lane delay registers.
    always_comb begin
        lane_ld  = 1'b0;
        lane_nxt = tap_idx;
        case (state)
            SW_IDLE: begin
                lane_ld  = cal_start;
                lane_nxt = '0;
            end
            SW_WAIT: begin
                lane_ld  = res.valid && (tap_idx != TAP_LAST);
                lane_nxt = tap_idx + TAP_W'(1);
            end
            SW_FINAL: begin
                lane_ld  = 1'b1;
                lane_nxt = any_pass ? centre : saved_tap;
            end
            default: ;
        endcase
    end

    // One delay register per lane, all loaded with the same value.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (lane_ld) begin
                lane_q[g] <= lane_nxt;
            end
        end
    end

    assign lane0_tap = lane_q[0];
    assign lane1_tap = lane_q[1];

    bist_handshake #(
        .CNT_W      (CNT_W),
        .EXPECT_CNT (EXPECT_CNT),
        .TIMEOUT    (TIMEOUT)
    ) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .status_i (bist_status),
        .go_o     (bist_go),
        .res_o    (res)
    );

    tap_window_track #(
        .TAP_W (TAP_W)
    ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (trk_clear),
        .upd        (trk_upd),
        .pass       (res.pass),
        .tap        (tap_idx),
        .any_pass_o (any_pass),
        .centre_o   (centre),
        .pass_cnt_o (pass_count)
    );

    // R2: while a test runs, both lanes carry the same setting.
    assert_lanes_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bist_go |-> (lane0_tap == lane1_tap));

    // R2: lanes stay fixed for the whole duration of a test.
    assert_lanes_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_go && $past(bist_go)) |-> $stable(lane0_tap));

    // R8: the completion pulse lasts one cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);

    // R8: no test is running while completion is signalled.
    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> !bist_go);

endmodule

// File: tb/tap_sweep_cal_tb.sv
// Bench for tap_sweep_cal. A behavioural self-test responder answers each
// launch from per-setting tables; the expected results come from the tables.
module tap_sweep_cal_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_start = 1'b0;
    logic [5:0] init_tap = '0;
    logic [8:0] bist_status;
    logic       bist_go;
    logic [5:0] lane0_tap;
    logic [5:0] lane1_tap;
    logic       cal_done;
    logic [6:0] pass_count;

    int n_checks = 0;
    int n_fail   = 0;

    bit       pass_map [64];
    bit       hang_map [64];
    bit       rand_lat = 1'b0;
    int       fixed_lat = 2;
    logic [7:0] bad_val [64];
    int       log_l0 [64];
    int       log_l1 [64];
    int       nlog = 0;
    int       n_done = 0;

    tap_sweep_cal u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cal_start   (cal_start),
        .init_tap    (init_tap),
        .bist_status (bist_status),
        .bist_go     (bist_go),
        .lane0_tap   (lane0_tap),
        .lane1_tap   (lane1_tap),
        .cal_done    (cal_done),
        .pass_count  (pass_count)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural self-test responder, updated away from the active edge.
    initial begin
        bit prev_go;
        int lat_cnt;
        int lat_goal;
        int cur;
        prev_go = 1'b0;
        lat_cnt = 0;
        lat_goal = 0;
        cur = 0;
        bist_status = '0;
        forever begin
            @(negedge clk);
            if (cal_done) n_done++;
            if (!bist_go) begin
                bist_status = '0;
                lat_cnt = 0;
            end else begin
                if (!prev_go) begin
                    if (nlog < 64) begin
                        log_l0[nlog] = lane0_tap;
                        log_l1[nlog] = lane1_tap;
                    end
                    nlog++;
                    cur = lane0_tap;
                    lat_cnt = 0;
                    lat_goal = rand_lat ? int'($urandom % 6) : fixed_lat;
                end
                if (!hang_map[cur]) begin
                    if (lat_cnt >= lat_goal)
                        bist_status = {(pass_map[cur] ? 8'd8 : bad_val[cur]), 1'b1};
                    lat_cnt++;
                end
            end
            prev_go = bist_go;
        end
    end

    function automatic int exp_passes();
        int n = 0;
        for (int t = 0; t < 64; t++) if (pass_map[t] && !hang_map[t]) n++;
        return n;
    endfunction

    function automatic int exp_final(input int init);
        int lo = -1;
        int hi = 0;
        for (int t = 0; t < 64; t++) begin
            if (pass_map[t] && !hang_map[t]) begin
                if (lo < 0) lo = t;
                hi = t;
            end
        end
        if (lo < 0) return init;
        return ((lo + hi) / 2) % 64;
    endfunction

    task automatic clear_maps();
        for (int t = 0; t < 64; t++) begin
            pass_map[t] = 1'b0;
            hang_map[t] = 1'b0;
            bad_val[t]  = 8'd0;
        end
    endtask

    task automatic run_cal(input int init, input bit inject, input string req);
        int waited = 0;
        bit injected = 1'b0;
        int e_fin = exp_final(init);
        int e_cnt = exp_passes();
        bit ord_ok = 1'b1;
        bit eq_ok = 1'b1;
        int logs;
        nlog = 0;
        n_done = 0;
        @(negedge clk);
        init_tap = 6'(init);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        init_tap = 6'(init ^ 21);
        while (!cal_done && waited < 30000) begin
            @(negedge clk);
            waited++;
            if (inject && !injected && nlog == 10) begin
                cal_start = 1'b1;
                injected = 1'b1;
            end else begin
                cal_start = 1'b0;
            end
        end
        cal_start = 1'b0;
        if (!cal_done) begin
            chk(1'b0, req, "watchdog waiting for cal_done", waited, 0);
            return;
        end
        // R5 / R6: final lanes; R8: lanes already final in the done cycle.
        chk(int'(lane0_tap) == e_fin, req, "R8 lane0 final", lane0_tap, e_fin);
        chk(int'(lane1_tap) == e_fin, req, "R8 lane1 final", lane1_tap, e_fin);
        // R7: pass count.
        chk(int'(pass_count) == e_cnt, "R7", "pass_count", pass_count, e_cnt);
        // R2: one launch per setting, ascending, lanes equal.
        logs = nlog;
        for (int i = 0; i < 64; i++) begin
            if (log_l0[i] != i) ord_ok = 1'b0;
            if (log_l0[i] != log_l1[i]) eq_ok = 1'b0;
        end
        chk(logs == 64, "R2", "launch count", logs, 64);
        chk(ord_ok, "R2", "ascending sweep order", ord_ok, 1);
        chk(eq_ok, "R2", "lanes equal at launch", eq_ok, 1);
        @(negedge clk);
        chk(cal_done == 1'b0, "R8", "done width one cycle", cal_done, 0);
        repeat (6) @(negedge clk);
        chk(n_done == 1, inject ? "R10" : "R8", "done pulses", n_done, 1);
        chk(nlog == 64, inject ? "R10" : "R2", "no launch after done", nlog, 64);
        chk(int'(lane0_tap) == e_fin, req, "lane hold after done", lane0_tap, e_fin);
    endtask

    // Global watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lo;
        int ln;
        void'($urandom(32'h1A2B3C4D));
        clear_maps();
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(cal_done == 1'b0, "R1", "cal_done in reset", cal_done, 0);
        chk(bist_go == 1'b0, "R1", "bist_go in reset", bist_go, 0);
        chk(lane0_tap == 6'd0 && lane1_tap == 6'd0, "R1", "lanes in reset", lane0_tap, 0);
        chk(pass_count == 7'd0, "R1", "pass_count in reset", pass_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bist_go == 1'b0, "R1", "bist_go idle after reset", bist_go, 0);

        // R5: all pass -> (0+63)/2 = 31.
        for (int t = 0; t < 64; t++) pass_map[t] = 1'b1;
        run_cal(12, 1'b0, "R5");

        // R6: nothing passes -> initial setting restored.
        clear_maps();
        for (int t = 0; t < 64; t++) bad_val[t] = 8'd3;
        run_cal(45, 1'b0, "R6");

        // R4: near-miss counts 7, 9, 0, 0x88 all fail; only 30..33 pass -> 31.
        clear_maps();
        for (int t = 0; t < 64; t++) begin
            case (t % 4)
                0: bad_val[t] = 8'd7;
                1: bad_val[t] = 8'd9;
                2: bad_val[t] = 8'd0;
                default: bad_val[t] = 8'h88;
            endcase
        end
        for (int t = 30; t < 34; t++) pass_map[t] = 1'b1;
        run_cal(5, 1'b0, "R4");

        // R5: single pass at the top setting -> 63.
        clear_maps();
        pass_map[63] = 1'b1;
        run_cal(0, 1'b0, "R5");

        // R5: single pass at setting 0 -> 0.
        clear_maps();
        pass_map[0] = 1'b1;
        run_cal(40, 1'b0, "R5");

        // R5: two isolated passes 5 and 50 -> 27.
        clear_maps();
        pass_map[5] = 1'b1;
        pass_map[50] = 1'b1;
        run_cal(9, 1'b0, "R5");

        // R9: hanging tests count as fails; window 10..20 with 20 hanging -> 14.
        clear_maps();
        for (int t = 10; t <= 20; t++) pass_map[t] = 1'b1;
        hang_map[20] = 1'b1;
        hang_map[40] = 1'b1;
        run_cal(33, 1'b0, "R9");

        // R9: the only passing setting hangs -> initial restored.
        clear_maps();
        pass_map[22] = 1'b1;
        hang_map[22] = 1'b1;
        run_cal(17, 1'b0, "R9");

        // R10: extra start mid-sweep ignored; window 8..16 -> 12.
        clear_maps();
        for (int t = 8; t <= 16; t++) pass_map[t] = 1'b1;
        run_cal(3, 1'b1, "R10");

        // R3 / R5 / R7: seeded random windows with random latency.
        rand_lat = 1'b1;
        for (int k = 0; k < 12; k++) begin
            clear_maps();
            lo = int'($urandom % 64);
            ln = int'($urandom % 20);
            for (int t = lo; t < 64 && t <= lo + ln; t++) pass_map[t] = 1'b1;
            for (int t = 0; t < 64; t++) begin
                if (($urandom % 16) == 0) pass_map[t] = 1'b1;
                bad_val[t] = 8'($urandom % 256);
                if (bad_val[t] == 8'd8) bad_val[t] = 8'd9;
            end
            if (k % 3 == 0) pass_map = '{default: 1'b0};
            run_cal(int'($urandom % 64), 1'b0, "R3");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule